// File: doc/BRIEF.md
# Boot mapping and remap controller

This block decides what answers at address zero once the chip leaves reset. While the external reset is held, it keeps sampling a boot-select pin. It latches the level seen at the end of the reset window as the boot memory type: a narrow 8-bit device or a 16-bit device, both reached through chip select 0. Out of reset, the low address region, which holds the exception vectors, is served by that boot device. The processor therefore starts from nonvolatile memory.

Software later sets a one-bit remap control over a small register bus. From then on the low region is served by internal SRAM, and the vectors can be rewritten. The remap is sticky. Only the external reset or an internal reset pulse clears it. The same decoder drives the external chip selects 1 to 7, and it keeps them shut until remap has happened. It raises an abort strobe for accesses in the external address space that hit nothing usable. Accesses to internal space never abort.

Top module: `boot_remap_ctrl`

## Requirements
- R1: `boot_16bit` equals the inverse of `boot_sel` at the last clock edge of the reset window, which is the edge where the rise of `rst_n` is first registered (`boot_sel`=1 gives an 8-bit boot device, `boot_16bit`=0). After that edge it holds whatever `boot_sel` does.
- R2: After reset the remap state is 0. Reading at `reg_addr`=0x04 returns 0 in bit 0, and every other bit is 0.
- R3: A write at `reg_addr`=0x04 with `reg_wdata`=1 sets the remap state on that clock edge, and reads at 0x04 then return 1.
- R4: A write with `reg_wdata`=0, and a write to any other address, leaves the remap state unchanged.
- R5: Once set, the remap state is cleared only by `rst_n` low or by a one-cycle `soft_rst` pulse. `soft_rst` wins over a same-cycle write.
- R6: Before remap, an access to an external bank of chip select 1 to 7 asserts no chip select and aborts.
- R7: After remap, an access to bank i (addresses 0x0040_0000 + i·0x10_0000 up to that plus 0xF_FFFF, i = 0 to 7) asserts only `cs[i]`.
- R8: An access in the external space 0x0040_0000 to 0xFFBF_FFFF that lies outside all eight banks aborts and asserts no chip select.
- R9: No access below 0x0040_0000 or at or above 0xFFC0_0000 aborts, whether it is mapped or not. Addresses 0x0020_0000 to 0x003F_FFFF select nothing.
- R10: All selects and `abort` are combinational on `acc_req` and are 0 whenever `acc_req` is 0, so an abort lasts exactly as long as its request strobe.
- R11: The low region 0x0000_0000 to 0x000F_FFFF, which holds the vectors at 0x00 to 0x20, asserts `cs[0]` before remap and `sram_sel` after remap.
- R12: Addresses 0x0010_0000 to 0x001F_FFFF always assert `sram_sel`. Addresses at or above 0xFFC0_0000 always assert `periph_sel`. Bank 0 is reachable at its external address both before and after remap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| soft_rst | input | 1 | Internal reset pulse; clears the remap state |
| boot_sel | input | 1 | Boot-select pin, sampled while in reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address (byte offset) |
| reg_wdata | input | 1 | Write data bit 0 |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| acc_req | input | 1 | Access request strobe |
| acc_addr | input | 32 | Access byte address |
| cs | output | 8 | External chip selects, active high |
| sram_sel | output | 1 | Internal SRAM select |
| periph_sel | output | 1 | Internal peripheral select |
| abort | output | 1 | Abort for an undefined or blocked external access |
| boot_16bit | output | 1 | Latched boot device width: 1 = 16-bit, 0 = 8-bit |

## Verification
The hardest case to reach from the ports is the boot latch when `boot_sel` is unsettled during reset. The bench toggles the pin on every cycle of a long reset, settles it only just before `rst_n` rises, and then flips it after release. This shows that only the end of the window counts. The gating of chip selects 1 to 7 needs the same bank addresses to be driven once before remap and once after, in one run. The stimulus table therefore walks a pre-remap phase and then issues the remap write itself before the post-remap rows. A second full reset with the opposite pin level confirms that both the latch and the sticky remap state follow the new reset.

// File: rtl/boot_remap_pkg.sv
package boot_remap_pkg;

  // Coarse region classes of an access address.
  typedef enum logic [2:0] {
    RGN_LOW    = 3'd0,  // vector / boot window at the bottom
    RGN_SRAM   = 3'd1,  // fixed home of internal SRAM
    RGN_INT_UD = 3'd2,  // internal, undefined
    RGN_EXT    = 3'd3,  // external bus space
    RGN_PERIPH = 3'd4   // internal peripherals
  } region_e;

endpackage

// File: rtl/rst_boot_sync.sv
module rst_boot_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic boot_sel,
  output logic rst_sync_n,
  output logic boot_16bit
);

  localparam int CHAIN_W = (SYNC_STAGES > 1) ? SYNC_STAGES - 1 : 1;

  logic [CHAIN_W-1:0] chain_q, chain_d;
  logic               rst_out_q;
  logic               hold_q;
  logic               boot_q, boot_d;
  logic               capture_en;

  // reset release chain: asserts at once, releases after SYNC_STAGES edges
  always_comb begin
    if (CHAIN_W > 1) chain_d = {chain_q[CHAIN_W-2:0], 1'b1};
    else             chain_d = '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q   <= '0;
      rst_out_q <= 1'b0;
    end else begin
      chain_q   <= chain_d;
      rst_out_q <= chain_q[CHAIN_W-1];
    end
  end

  // capture window flag: low while reset is held, high from the first
  // registered edge after release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= 1'b1;
  end

  assign capture_en = ~hold_q;

  // boot pin sample: keeps tracking the pin through the window, the last
  // sampled level wins
  always_comb begin
    boot_d = boot_q;
    if (capture_en) boot_d = boot_sel;
  end

  always_ff @(posedge clk) begin
    boot_q <= boot_d;
  end

  assign rst_sync_n = rst_out_q;
  assign boot_16bit = ~boot_q;

endmodule

// File: rtl/remap_reg.sv
module remap_reg #(
  parameter int              REG_AW    = 8,
  parameter int              REG_DW    = 32,
  parameter logic [REG_AW-1:0] REMAP_OFS = 8'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic              wr_bit,
  output logic [REG_DW-1:0] rdata,
  output logic              remap_q
);

  logic hit;
  logic set_req;
  logic remap_d;

  assign hit     = (addr == REMAP_OFS);
  assign set_req = wr_en & hit & wr_bit;

  // sticky: only a set request moves it up, only an internal reset down
  always_comb begin
    remap_d = remap_q;
    if (set_req)  remap_d = 1'b1;
    if (soft_rst) remap_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) remap_q <= 1'b0;
    else        remap_q <= remap_d;
  end

  always_comb begin
    rdata = '0;
    if (hit) rdata[0] = remap_q;
  end

endmodule

// File: rtl/addr_decode.sv
module addr_decode
  import boot_remap_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter int                NUM_CS      = 8,
  parameter int                BANK_SHIFT  = 20,
  parameter int                LOW_SHIFT   = 20,
  parameter int                SRAM_SHIFT  = 20,
  parameter logic [ADDR_W-1:0] SRAM_BASE   = 32'h0010_0000,
  parameter logic [ADDR_W-1:0] EXT_BASE    = 32'h0040_0000,
  parameter logic [ADDR_W-1:0] PERIPH_BASE = 32'hFFC0_0000
) (
  input  logic              remap,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_CS-1:0] cs,
  output logic              sram_sel,
  output logic              periph_sel,
  output logic              abort
);

  localparam int BIDX_W = ADDR_W - BANK_SHIFT;
  localparam int SIDX_W = ADDR_W - SRAM_SHIFT;
  localparam logic [ADDR_W-1:0] SRAM_IDX = SRAM_BASE >> SRAM_SHIFT;

  region_e             rgn;
  logic [NUM_CS-1:0]   bank_hit;
  logic [NUM_CS-1:0]   bank_ok;
  logic                in_low;
  logic                in_sram;
  logic                in_ext;
  logic                in_per;

  assign in_low  = (addr[ADDR_W-1:LOW_SHIFT] == '0);
  assign in_sram = (addr[ADDR_W-1:SRAM_SHIFT] == SRAM_IDX[SIDX_W-1:0]);
  assign in_ext  = (addr >= EXT_BASE) && (addr < PERIPH_BASE);
  assign in_per  = (addr >= PERIPH_BASE);

  always_comb begin
    if      (in_per)  rgn = RGN_PERIPH;
    else if (in_ext)  rgn = RGN_EXT;
    else if (in_low)  rgn = RGN_LOW;
    else if (in_sram) rgn = RGN_SRAM;
    else              rgn = RGN_INT_UD;
  end

  // one bank window per chip select; select 0 stays open, the rest wait
  // for the remap
  for (genvar i = 0; i < NUM_CS; i++) begin : g_bank
    localparam logic [ADDR_W-1:0] BANK_IDX = (EXT_BASE >> BANK_SHIFT) + ADDR_W'(i);
    assign bank_hit[i] = (rgn == RGN_EXT) &&
                         (addr[ADDR_W-1:BANK_SHIFT] == BANK_IDX[BIDX_W-1:0]);
    if (i == 0) begin : g_boot
      assign bank_ok[i] = bank_hit[i];
      assign cs[i]      = req & (bank_ok[i] | ((rgn == RGN_LOW) & ~remap));
    end else begin : g_gated
      assign bank_ok[i] = bank_hit[i] & remap;
      assign cs[i]      = req & bank_ok[i];
    end
  end

  assign sram_sel   = req & ((rgn == RGN_SRAM) | ((rgn == RGN_LOW) & remap));
  assign periph_sel = req & (rgn == RGN_PERIPH);
  assign abort      = req & (rgn == RGN_EXT) & ~(|bank_ok);

endmodule

// File: rtl/boot_remap_ctrl.sv
module boot_remap_ctrl #(
  parameter int                ADDR_W      = 32,
  parameter int                NUM_CS      = 8,
  parameter int                BANK_SHIFT  = 20,
  parameter int                LOW_SHIFT   = 20,
  parameter int                SRAM_SHIFT  = 20,
  parameter logic [ADDR_W-1:0] SRAM_BASE   = 32'h0010_0000,
  parameter logic [ADDR_W-1:0] EXT_BASE    = 32'h0040_0000,
  parameter logic [ADDR_W-1:0] PERIPH_BASE = 32'hFFC0_0000,
  parameter int                REG_AW      = 8,
  parameter int                REG_DW      = 32,
  parameter logic [REG_AW-1:0] REMAP_OFS   = 8'h04,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              boot_sel,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              acc_req,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic [NUM_CS-1:0] cs,
  output logic              sram_sel,
  output logic              periph_sel,
  output logic              abort,
  output logic              boot_16bit
);

  logic rst_sync_n;
  logic remap_q;

  rst_boot_sync #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .boot_sel   (boot_sel),
    .rst_sync_n (rst_sync_n),
    .boot_16bit (boot_16bit)
  );

  remap_reg #(
    .REG_AW    (REG_AW),
    .REG_DW    (REG_DW),
    .REMAP_OFS (REMAP_OFS)
  ) u_remap (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .soft_rst(soft_rst),
    .wr_en   (reg_wr),
    .addr    (reg_addr),
    .wr_bit  (reg_wdata),
    .rdata   (reg_rdata),
    .remap_q (remap_q)
  );

  addr_decode #(
    .ADDR_W      (ADDR_W),
    .NUM_CS      (NUM_CS),
    .BANK_SHIFT  (BANK_SHIFT),
    .LOW_SHIFT   (LOW_SHIFT),
    .SRAM_SHIFT  (SRAM_SHIFT),
    .SRAM_BASE   (SRAM_BASE),
    .EXT_BASE    (EXT_BASE),
    .PERIPH_BASE (PERIPH_BASE)
  ) u_dec (
    .remap      (remap_q),
    .req        (acc_req),
    .addr       (acc_addr),
    .cs         (cs),
    .sram_sel   (sram_sel),
    .periph_sel (periph_sel),
    .abort      (abort)
  );

endmodule

// File: rtl/boot_remap_chk.sv
module boot_remap_chk #(
  parameter int                ADDR_W    = 32,
  parameter int                NUM_CS    = 8,
  parameter logic [ADDR_W-1:0] EXT_BASE  = 32'h0040_0000,
  parameter int                REG_AW    = 8,
  parameter logic [REG_AW-1:0] REMAP_OFS = 8'h04
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              soft_rst,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic              reg_wdata,
  input logic              acc_req,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [NUM_CS-1:0] cs,
  input logic              sram_sel,
  input logic              periph_sel,
  input logic              abort,
  input logic              boot_16bit,
  input logic              remap_q
);

  AST_BOOT_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $stable(boot_16bit)); // R1

  AST_REMAP_SET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_wr && reg_wdata && (reg_addr == REMAP_OFS) && !soft_rst |=> remap_q); // R3

  AST_ZERO_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_wr && !reg_wdata && !remap_q |=> !remap_q); // R4

  AST_REMAP_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    remap_q && !soft_rst |=> remap_q); // R5

  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    soft_rst |=> !remap_q); // R5

  AST_GATED_SELECTS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !remap_q |-> (cs[NUM_CS-1:1] == '0)); // R6

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({cs, sram_sel, periph_sel, abort})); // R7

  AST_INTERNAL_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    acc_req && (acc_addr < EXT_BASE) |-> !abort); // R9

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !acc_req |-> !abort && (cs == '0) && !sram_sel && !periph_sel); // R10

  AST_VECTOR_BOOT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    acc_req && (acc_addr <= 32'h20) && !remap_q |-> cs[0]); // R11

endmodule

bind boot_remap_ctrl boot_remap_chk #(
  .ADDR_W    (ADDR_W),
  .NUM_CS    (NUM_CS),
  .EXT_BASE  (EXT_BASE),
  .REG_AW    (REG_AW),
  .REMAP_OFS (REMAP_OFS)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .soft_rst   (soft_rst),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .acc_req    (acc_req),
  .acc_addr   (acc_addr),
  .cs         (cs),
  .sram_sel   (sram_sel),
  .periph_sel (periph_sel),
  .abort      (abort),
  .boot_16bit (boot_16bit),
  .remap_q    (remap_q)
);

// File: tb/boot_remap_ctrl_bench.sv
`timescale 1ns/1ps
module boot_remap_ctrl_bench;

  logic        clk;
  logic        rst_n;
  logic        soft_rst;
  logic        boot_sel;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic        reg_wdata;
  logic [31:0] reg_rdata;
  logic        acc_req;
  logic [31:0] acc_addr;
  logic [7:0]  cs;
  logic        sram_sel;
  logic        periph_sel;
  logic        abort;
  logic        boot_16bit;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  boot_remap_ctrl u_boot_remap_ctrl (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .boot_sel(boot_sel),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .acc_req(acc_req), .acc_addr(acc_addr),
    .cs(cs), .sram_sel(sram_sel), .periph_sel(periph_sel),
    .abort(abort), .boot_16bit(boot_16bit)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic        rm;      // row needs remap done first
    logic [31:0] addr;
    logic [7:0]  cs;
    logic        sram;
    logic        per;
    logic        abt;
    logic [3:0]  req;     // requirement number for the message
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0000_0000, 8'h01, 1'b0, 1'b0, 1'b0, 4'd11}, // R11 reset vector
    '{1'b0, 32'h0000_001C, 8'h01, 1'b0, 1'b0, 1'b0, 4'd11}, // R11
    '{1'b0, 32'h000F_FFFC, 8'h01, 1'b0, 1'b0, 1'b0, 4'd11}, // R11 end of low region
    '{1'b0, 32'h0010_0040, 8'h00, 1'b1, 1'b0, 1'b0, 4'd12}, // R12 SRAM home
    '{1'b0, 32'h0025_0000, 8'h00, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 internal undefined
    '{1'b0, 32'hFFC0_1000, 8'h00, 1'b0, 1'b1, 1'b0, 4'd12}, // R12 peripherals
    '{1'b0, 32'h0040_0010, 8'h01, 1'b0, 1'b0, 1'b0, 4'd12}, // R12 bank 0 before remap
    '{1'b0, 32'h0050_0000, 8'h00, 1'b0, 1'b0, 1'b1, 4'd6},  // R6 bank 1 blocked
    '{1'b0, 32'h00B0_0000, 8'h00, 1'b0, 1'b0, 1'b1, 4'd6},  // R6 bank 7 blocked
    '{1'b0, 32'h00C0_0000, 8'h00, 1'b0, 1'b0, 1'b1, 4'd8},  // R8 past last bank
    '{1'b1, 32'h0000_0000, 8'h00, 1'b1, 1'b0, 1'b0, 4'd11}, // R11 vector now SRAM
    '{1'b1, 32'h0000_0020, 8'h00, 1'b1, 1'b0, 1'b0, 4'd11}, // R11
    '{1'b1, 32'h0050_0000, 8'h02, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 bank 1
    '{1'b1, 32'h00BF_FFFC, 8'h80, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 bank 7 top
    '{1'b1, 32'h0040_0000, 8'h01, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 bank 0
    '{1'b1, 32'h00C0_0000, 8'h00, 1'b0, 1'b0, 1'b1, 4'd8},  // R8
    '{1'b1, 32'hFFBF_FFFC, 8'h00, 1'b0, 1'b0, 1'b1, 4'd8},  // R8 top of ext space
    '{1'b1, 32'hFFFF_FFFC, 8'h00, 1'b0, 1'b1, 1'b0, 4'd9},  // R9 no abort above
    '{1'b1, 32'h003F_FFFC, 8'h00, 1'b0, 1'b0, 1'b0, 4'd9}   // R9 just below ext
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 1'b0;
  endtask

  task automatic read_remap(input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = 8'h04;
    #1;
    chk(reg_rdata == exp, tag, 64'(reg_rdata), 64'(exp));
  endtask

  // hold reset with a toggling pin, settle it to last_lvl, release, then flip
  task automatic do_reset(input logic last_lvl);
    @(negedge clk);
    rst_n = 1'b0;
    for (int k = 0; k < 14; k++) begin
      @(negedge clk);
      boot_sel = k[0];
    end
    @(negedge clk);
    boot_sel = last_lvl;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    boot_sel = ~last_lvl;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic rm_now;
    rst_n = 1'b0; soft_rst = 1'b0; boot_sel = 1'b0;
    reg_wr = 1'b0; reg_addr = 8'h00; reg_wdata = 1'b0;
    acc_req = 1'b0; acc_addr = '0;

    do_reset(1'b1);
    #1;
    chk(boot_16bit == 1'b0, "R1 boot latch 8-bit", 64'(boot_16bit), 64'd0);
    read_remap(32'd0, "R2 remap clear after reset");
    @(negedge clk);
    acc_addr = 32'h0050_0000; #1;
    chk({cs, sram_sel, periph_sel, abort} == '0, "R10 idle with no request",
        64'({cs, sram_sel, periph_sel, abort}), 64'd0);

    reg_write(8'h04, 1'b0);
    read_remap(32'd0, "R4 zero write ignored");
    reg_write(8'h08, 1'b1);
    read_remap(32'd0, "R4 other address ignored");
    @(negedge clk);
    reg_addr = 8'h08; #1;
    chk(reg_rdata == 32'd0, "R2 other address reads zero", 64'(reg_rdata), 64'd0);

    rm_now = 1'b0;
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].rm && !rm_now) begin
        reg_write(8'h04, 1'b1);
        rm_now = 1'b1;
        read_remap(32'd1, "R3 remap set reads back");
      end
      @(negedge clk);
      acc_req = 1'b1; acc_addr = VECS[i].addr;
      #1;
      chk({cs, sram_sel, periph_sel, abort} ==
          {VECS[i].cs, VECS[i].sram, VECS[i].per, VECS[i].abt},
          $sformatf("R%0d decode of %h", VECS[i].req, VECS[i].addr),
          64'({cs, sram_sel, periph_sel, abort}),
          64'({VECS[i].cs, VECS[i].sram, VECS[i].per, VECS[i].abt}));
      @(negedge clk);
      acc_req = 1'b0;
      #1;
      if (VECS[i].abt)
        chk(abort == 1'b0, "R10 abort ends with strobe", 64'(abort), 64'd0);
    end

    reg_write(8'h04, 1'b0);
    read_remap(32'd1, "R4 zero write keeps remap");
    reg_write(8'h10, 1'b0);
    read_remap(32'd1, "R5 unrelated write keeps remap");

    @(negedge clk);
    soft_rst = 1'b1; reg_wr = 1'b1; reg_addr = 8'h04; reg_wdata = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0; reg_wr = 1'b0; reg_wdata = 1'b0;
    read_remap(32'd0, "R5 soft reset wins over write");
    @(negedge clk);
    acc_req = 1'b1; acc_addr = 32'h0000_0000; #1;
    chk(cs == 8'h01 && !sram_sel, "R5 boot mapping back after soft reset",
        64'({cs, sram_sel}), 64'h002);
    @(negedge clk);
    acc_req = 1'b0;

    reg_write(8'h04, 1'b1);
    read_remap(32'd1, "R3 remap set again");
    do_reset(1'b0);
    #1;
    chk(boot_16bit == 1'b1, "R1 boot latch 16-bit", 64'(boot_16bit), 64'd1);
    read_remap(32'd0, "R5 external reset clears remap");
    @(negedge clk);
    boot_sel = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk(boot_16bit == 1'b1, "R1 pin ignored after release", 64'(boot_16bit), 64'd1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule